// File: doc/BRIEF.md
# Paged SPI Register Access Sequencer

This block carries out one register access at a time on a switch-style device that sits on SPI. The device exposes its registers in 256-register pages. A host request gives the direction, the page, the register and a byte count. The block then builds the full series of SPI frames that such an access needs. It first polls the device status until the device is no longer busy. It then selects the page. A write follows with a single frame. A read takes three more steps: a dummy read of the target register, polling until the device reports the read data ready, and a fetch of that data from a fixed data window.

The block talks to a byte-level SPI master. It hands over one byte per `spi_start` pulse and tells the master whether chip select must stay asserted after that byte. It waits for `spi_byte_done` before it issues the next byte. Between two polls of the same status bit the block waits a programmable number of clock cycles. It gives up with an error when the retry budget runs out. The bit-serial engine and the clock divider belong to the master and are not part of this block.

Top module: `paged_reg_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_done` and `spi_start` are 0. A request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the response has been given.
- R2: Every access with a valid length begins with status frames of three bytes: 0x60, 0xFE, then one received byte, with 0x00 sent in the receive slot. A frame is repeated while bit 7 of the received byte is 1, and bit 5 does not matter here. At least WAIT_CYCLES clock cycles separate the start of one poll frame from the start of the next.
- R3: If MAX_TRIES status frames in a row all show bit 7 set, the block ends the access with an error and sends no further frame.
- R4: Once bit 7 reads 0, the block sends the page frame 0x61, 0xFF, page.
- R5: A write then sends one frame: 0x61, the register, and then `req_len` bytes of `req_wdata` with the least significant byte first. For a length of 6, only the low six bytes are sent.
- R6: A read sends the dummy frame 0x60, register, 0x00. It then sends status frames (0x60, 0xFE, 0x00) until bit 5 of the received byte is 1, with the same wait between polls as in R2.
- R7: If MAX_TRIES status frames after the dummy read all show bit 5 clear, the access ends with an error and no data frame is sent.
- R8: A read finishes with the frame 0x60, 0xF0, followed by `req_len` receive slots that each send 0x00. The first byte received becomes bits 7:0 of `rsp_rdata`, and bytes beyond `req_len` read as zero.
- R9: Each byte is one `spi_start` pulse, and the next pulse comes only after `spi_byte_done`. `spi_cs_hold` is 1 on every byte of a frame except the last.
- R10: `rsp_done` is a one-cycle pulse. `rsp_err` is high only together with `rsp_done`. `rsp_rdata` is zero whenever `rsp_err` is high and after any write.
- R11: A `req_len` other than 1, 2, 4, 6 or 8 ends the request with `rsp_done` and `rsp_err` and no SPI byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Register page |
| req_reg | input | 8 | Register within page |
| req_len | input | 4 | Byte count (1, 2, 4, 6, 8) |
| req_wdata | input | 64 | Write value, least significant byte sent first |
| rsp_done | output | 1 | Access finished (one cycle) |
| rsp_err | output | 1 | Access failed, valid with rsp_done |
| rsp_rdata | output | 64 | Read value, held until next request |
| spi_start | output | 1 | Start one byte transfer |
| spi_tx | output | 8 | Byte to send |
| spi_cs_hold | output | 1 | Keep chip select asserted after this byte |
| spi_rx | input | 8 | Byte received, valid with spi_byte_done |
| spi_byte_done | input | 1 | Byte transfer finished |

## Verification
The bench builds the block with WAIT_CYCLES = 16 and keeps the default MAX_TRIES = 10. With a wait that short, a run through all ten busy polls, or all ten acknowledge polls, costs only a few hundred cycles. This lets the bench aim directly at both timeout edges (nine failed polls then success, and ten failed polls) and still check that each poll gap is at least the programmed wait. The device model in the bench sets how many busy and not-ready answers it gives for each access, and it logs every byte together with its chip-select state so that the whole frame sequence can be compared.

// File: rtl/preg_pkg.sv
`timescale 1ns/1ps
package preg_pkg;
  localparam logic [7:0] CMD_RD    = 8'h60;
  localparam logic [7:0] CMD_WR    = 8'h61;
  localparam logic [7:0] ADDR_STAT = 8'hFE;
  localparam logic [7:0] ADDR_PAGE = 8'hFF;
  localparam logic [7:0] ADDR_WIN  = 8'hF0;
  localparam int BUSY_BIT = 7;
  localparam int ACK_BIT  = 5;
  localparam int MAX_LEN  = 8;
  localparam int DATA_W   = 8 * MAX_LEN;
  localparam int LANE_W   = $clog2(MAX_LEN);

  typedef enum logic [1:0] {PH_IDLE, PH_XFER, PH_WAIT, PH_FIN} phase_e;
  typedef enum logic [2:0] {FR_BUSY, FR_PAGE, FR_WRITE, FR_DUMMY, FR_ACK, FR_DATA} frame_e;

  function automatic logic len_ok(input logic [3:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd6) || (n == 4'd8);
  endfunction
endpackage

// File: rtl/preg_rst_sync.sv
`timescale 1ns/1ps
module preg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/preg_wait_timer.sv
`timescale 1ns/1ps
module preg_wait_timer #(
  parameter int CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CW'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/preg_rx_lanes.sv
`timescale 1ns/1ps
module preg_rx_lanes #(
  parameter int LANES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     capture,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               din,
  output logic [8*LANES-1:0]       dout
);
  localparam int LW = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    logic       hit;

    assign hit = capture && (lane == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     byte_q <= 8'h00;
      else if (clear) byte_q <= 8'h00;
      else if (hit)   byte_q <= din;
    end

    assign dout[8*g +: 8] = byte_q;
  end
endmodule

// File: rtl/paged_reg_seq.sv
`timescale 1ns/1ps
module paged_reg_seq
  import preg_pkg::*;
#(
  parameter int WAIT_CYCLES = 200000,
  parameter int MAX_TRIES   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_page,
  input  logic [7:0]        req_reg,
  input  logic [3:0]        req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  output logic              spi_cs_hold,
  input  logic [7:0]        spi_rx,
  input  logic              spi_byte_done
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  logic              rst_ns;
  phase_e            phase_q, phase_d;
  frame_e            frame_q, frame_d;
  logic [3:0]        idx_q, idx_d;
  logic              pend_q, pend_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic              err_q, err_d;
  logic              load_req, timer_start, timer_exp, lane_clear;
  logic              write_q;
  logic [7:0]        page_q, reg_q;
  logic [3:0]        len_q;
  logic [DATA_W-1:0] wdata_q;
  logic [3:0]        frame_len;
  logic              last_byte, byte_ev, rx_cap, retry_last;
  logic [LANE_W-1:0] lane;

  preg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  preg_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ns),
    .start   (timer_start),
    .expired (timer_exp)
  );

  preg_rx_lanes #(.LANES(MAX_LEN)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clear   (lane_clear),
    .capture (rx_cap),
    .lane    (lane),
    .din     (spi_rx),
    .dout    (rsp_rdata)
  );

  // frame geometry
  assign frame_len  = ((frame_q == FR_WRITE) || (frame_q == FR_DATA)) ? (len_q + 4'd2) : 4'd3;
  assign last_byte  = (idx_q == (frame_len - 4'd1));
  assign lane       = LANE_W'(idx_q - 4'd2);
  assign byte_ev    = (phase_q == PH_XFER) && pend_q && spi_byte_done;
  assign rx_cap     = byte_ev && (frame_q == FR_DATA) && (idx_q >= 4'd2);
  assign retry_last = (try_q == TRY_W'(MAX_TRIES - 1));

  // byte to send
  always_comb begin
    spi_tx = 8'h00;
    if (idx_q == 4'd0) begin
      spi_tx = ((frame_q == FR_PAGE) || (frame_q == FR_WRITE)) ? CMD_WR : CMD_RD;
    end else if (idx_q == 4'd1) begin
      case (frame_q)
        FR_BUSY, FR_ACK: spi_tx = ADDR_STAT;
        FR_PAGE:         spi_tx = ADDR_PAGE;
        FR_DATA:         spi_tx = ADDR_WIN;
        default:         spi_tx = reg_q;
      endcase
    end else begin
      case (frame_q)
        FR_PAGE:  spi_tx = page_q;
        FR_WRITE: spi_tx = wdata_q[{lane, 3'b000} +: 8];
        default:  spi_tx = 8'h00;
      endcase
    end
  end

  assign spi_start   = (phase_q == PH_XFER) && !pend_q;
  assign spi_cs_hold = !last_byte;
  assign req_ready   = (phase_q == PH_IDLE);
  assign rsp_done    = (phase_q == PH_FIN);
  assign rsp_err     = (phase_q == PH_FIN) && err_q;

  // next state
  always_comb begin
    phase_d     = phase_q;
    frame_d     = frame_q;
    idx_d       = idx_q;
    pend_d      = pend_q;
    try_d       = try_q;
    err_d       = err_q;
    load_req    = 1'b0;
    lane_clear  = 1'b0;
    timer_start = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          load_req   = 1'b1;
          lane_clear = 1'b1;
          try_d      = '0;
          idx_d      = 4'd0;
          pend_d     = 1'b0;
          frame_d    = FR_BUSY;
          if (len_ok(req_len)) begin
            err_d   = 1'b0;
            phase_d = PH_XFER;
          end else begin
            err_d   = 1'b1;
            phase_d = PH_FIN;
          end
        end
      end
      PH_XFER: begin
        if (spi_start) pend_d = 1'b1;
        if (byte_ev) begin
          pend_d = 1'b0;
          if (!last_byte) begin
            idx_d = idx_q + 4'd1;
          end else begin
            idx_d = 4'd0;
            case (frame_q)
              FR_BUSY, FR_ACK: begin
                if (((frame_q == FR_BUSY) && !spi_rx[BUSY_BIT]) ||
                    ((frame_q == FR_ACK)  &&  spi_rx[ACK_BIT])) begin
                  try_d   = '0;
                  frame_d = (frame_q == FR_BUSY) ? FR_PAGE : FR_DATA;
                end else if (retry_last) begin
                  err_d   = 1'b1;
                  phase_d = PH_FIN;
                end else begin
                  try_d       = try_q + 1'b1;
                  phase_d     = PH_WAIT;
                  timer_start = 1'b1;
                end
              end
              FR_PAGE:  frame_d = write_q ? FR_WRITE : FR_DUMMY;
              FR_DUMMY: begin
                frame_d = FR_ACK;
                try_d   = '0;
              end
              default:  phase_d = PH_FIN;
            endcase
          end
        end
      end
      PH_WAIT: begin
        if (timer_exp) phase_d = PH_XFER;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_IDLE;
      frame_q <= FR_BUSY;
      idx_q   <= 4'd0;
      pend_q  <= 1'b0;
      try_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      try_q   <= try_d;
      err_q   <= err_d;
    end
  end

  // request capture, enable only
  always_ff @(posedge clk) begin
    if (load_req) begin
      write_q <= req_write;
      page_q  <= req_page;
      reg_q   <= req_reg;
      len_q   <= req_len;
      wdata_q <= req_wdata;
    end
  end
endmodule

// File: rtl/preg_seq_chk.sv
`timescale 1ns/1ps
module preg_seq_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_len,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic          spi_start,
  input logic          spi_byte_done
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             out_q <= 1'b0;
    else if (spi_start)     out_q <= 1'b1;
    else if (spi_byte_done) out_q <= 1'b0;
  end

  // R1
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !out_q);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  // R11
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_len inside {4'd1, 4'd2, 4'd4, 4'd6, 4'd8}))
      |=> (rsp_done && rsp_err));
endmodule

bind paged_reg_seq preg_seq_chk #(.DW(preg_pkg::DATA_W)) u_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_len       (req_len),
  .rsp_done      (rsp_done),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .spi_start     (spi_start),
  .spi_byte_done (spi_byte_done)
);

// File: tb/test_paged_reg_seq.sv
`timescale 1ns/1ps
module test_paged_reg_seq;
  localparam int WAIT  = 16;
  localparam int TRIES = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_page = 8'h00;
  logic [7:0]  req_reg = 8'h00;
  logic [3:0]  req_len = 4'd1;
  logic [63:0] req_wdata = 64'h0;
  logic        rsp_done, rsp_err;
  logic [63:0] rsp_rdata;
  logic        spi_start, spi_cs_hold;
  logic [7:0]  spi_tx;
  logic [7:0]  spi_rx = 8'h00;
  logic        spi_byte_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  paged_reg_seq #(.WAIT_CYCLES(WAIT), .MAX_TRIES(TRIES)) i_paged_reg_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_reg(req_reg),
    .req_len(req_len), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .spi_start(spi_start),
    .spi_tx(spi_tx), .spi_cs_hold(spi_cs_hold), .spi_rx(spi_rx),
    .spi_byte_done(spi_byte_done)
  );

  // device model settings, written only by the stimulus process
  int cfg_busy = 0;
  int cfg_ack  = 0;

  function automatic logic [7:0] dev_byte(input logic [7:0] p, input logic [7:0] r, input int i);
    return 8'((int'(p) * 13) ^ (int'(r) + 60) ^ (i * 71));
  endfunction

  // byte-level SPI master and device model
  logic [8:0] blog [0:511];
  int         blog_n = 0;
  int         ftime [0:63];
  int         fr_n = 0;
  int         cyc = 0;
  int         s_pos = 0, cnt = 0, stat_n = 0, ack_n = 0;
  bit         rd_pend = 0;
  logic [7:0] s_cmd = 0, s_addr = 0, s_page = 0, s_rdreg = 0, rx_hold = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    spi_byte_done <= 1'b0;
    if (req_valid && req_ready) begin
      stat_n = 0; ack_n = 0; rd_pend = 0; blog_n = 0; fr_n = 0; s_pos = 0;
    end
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        spi_byte_done <= 1'b1;
        spi_rx        <= rx_hold;
      end
    end
    if (spi_start) begin
      if (blog_n < 512) blog[blog_n] = {!spi_cs_hold, spi_tx};
      blog_n = blog_n + 1;
      rx_hold = 8'h00;
      if (s_pos == 0) begin
        s_cmd = spi_tx;
        if (fr_n < 64) ftime[fr_n] = cyc;
        fr_n = fr_n + 1;
      end else if (s_pos == 1) begin
        s_addr = spi_tx;
      end else if (s_cmd == 8'h60 && s_addr == 8'hFE) begin
        if (rd_pend) rx_hold = (ack_n >= cfg_ack) ? 8'h21 : 8'h01;
        else         rx_hold = (stat_n < cfg_busy) ? 8'hA0 : 8'h20;
      end else if (s_cmd == 8'h60 && s_addr == 8'hF0) begin
        rx_hold = dev_byte(s_page, s_rdreg, s_pos - 2);
      end else if (s_cmd == 8'h60) begin
        rx_hold = 8'h5A;
      end else if (s_cmd == 8'h61 && s_addr == 8'hFF) begin
        s_page = spi_tx;
      end
      cnt = 2;
      if (!spi_cs_hold) begin
        if (s_cmd == 8'h60 && s_addr == 8'hFE) begin
          if (rd_pend) ack_n = ack_n + 1;
          else         stat_n = stat_n + 1;
        end else if (s_cmd == 8'h60 && s_addr == 8'hF0) begin
          rd_pend = 0;
        end else if (s_cmd == 8'h60) begin
          rd_pend = 1; s_rdreg = s_addr;
        end
        s_pos = 0;
      end else begin
        s_pos = s_pos + 1;
      end
    end
  end

  // expected byte stream
  logic [8:0] exp_b [0:511];
  int         exp_n;

  task automatic push(input bit last, input logic [7:0] b);
    exp_b[exp_n] = {last, b};
    exp_n = exp_n + 1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit w, input logic [7:0] pg, input logic [7:0] rg,
                         input logic [3:0] ln, input logic [63:0] wd,
                         input int busy, input int ack, input string req);
    bit exp_err;
    logic [63:0] exp_rd;
    bit got_err;
    logic [63:0] got_rd;
    int t;
    bit same;
    int nb;
    cfg_busy = busy;
    cfg_ack  = ack;
    while (!req_ready) @(negedge clk);
    req_write = w; req_page = pg; req_reg = rg; req_len = ln; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_done && t < 5000) begin
      @(negedge clk);
      t = t + 1;
    end
    got_err = rsp_err;
    got_rd  = rsp_rdata;
    // expected outcome
    exp_n = 0; exp_err = 0; exp_rd = 64'h0;
    if (!(ln inside {4'd1, 4'd2, 4'd4, 4'd6, 4'd8})) begin
      exp_err = 1;
    end else begin
      nb = (busy >= TRIES) ? TRIES : busy + 1;
      for (int k = 0; k < nb; k++) begin push(0, 8'h60); push(0, 8'hFE); push(1, 8'h00); end
      if (busy >= TRIES) exp_err = 1;
      else begin
        push(0, 8'h61); push(0, 8'hFF); push(1, pg);
        if (w) begin
          push(0, 8'h61); push(0, rg);
          for (int i = 0; i < int'(ln); i++) push(i == int'(ln) - 1, wd[8*i +: 8]);
        end else begin
          push(0, 8'h60); push(0, rg); push(1, 8'h00);
          nb = (ack >= TRIES) ? TRIES : ack + 1;
          for (int k = 0; k < nb; k++) begin push(0, 8'h60); push(0, 8'hFE); push(1, 8'h00); end
          if (ack >= TRIES) exp_err = 1;
          else begin
            push(0, 8'h60); push(0, 8'hF0);
            for (int i = 0; i < int'(ln); i++) begin
              push(i == int'(ln) - 1, 8'h00);
              exp_rd[8*i +: 8] = dev_byte(pg, rg, i);
            end
          end
        end
      end
    end
    check(t < 5000, req, "done seen", 64'(t), 64'd0);
    check(got_err == exp_err, req, "error flag", 64'(got_err), 64'(exp_err));
    check(got_rd == exp_rd, req, "read data (R8 R10)", got_rd, exp_rd);
    same = (blog_n == exp_n);
    for (int i = 0; i < exp_n && same; i++) if (blog[i] != exp_b[i]) same = 0;
    check(same, req, "byte stream and cs hold (R9)", 64'(blog_n), 64'(exp_n));
    @(negedge clk);
    check(!rsp_done, "R10", "done single cycle", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    int unsigned seed;
    int lens [5] = '{1, 2, 4, 6, 8};
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    check(rsp_done == 1'b0,  "R1", "done after reset",  64'(rsp_done), 64'd0);
    check(spi_start == 1'b0, "R1", "start after reset", 64'(spi_start), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_txn(1, 8'h12, 8'h34, 4'd1, 64'h00000000000000AB, 0, 0, "R4 R5");
    run_txn(1, 8'h02, 8'h10, 4'd6, 64'hFFEEDDCCBBAA9988, 0, 0, "R5");
    run_txn(1, 8'h03, 8'h20, 4'd8, 64'h0123456789ABCDEF, 1, 0, "R5");
    run_txn(0, 8'h04, 8'h30, 4'd8, 64'h0, 0, 0, "R8");
    run_txn(0, 8'h05, 8'h44, 4'd2, 64'h0, 2, 0, "R2");
    check(fr_n >= 2 && (ftime[1] - ftime[0]) >= WAIT, "R2", "poll gap",
          64'(ftime[1] - ftime[0]), 64'(WAIT));
    check(fr_n >= 3 && (ftime[2] - ftime[1]) >= WAIT, "R2", "poll gap 2",
          64'(ftime[2] - ftime[1]), 64'(WAIT));
    run_txn(0, 8'h06, 8'h50, 4'd4, 64'h0, 0, 3, "R6");
    check(fr_n >= 6 && (ftime[5] - ftime[4]) >= WAIT, "R6", "ack poll gap",
          64'(ftime[5] - ftime[4]), 64'(WAIT));
    run_txn(1, 8'h07, 8'h60, 4'd4, 64'h11223344, TRIES - 1, 0, "R2");
    run_txn(1, 8'h08, 8'h61, 4'd4, 64'h55667788, TRIES, 0, "R3");
    run_txn(0, 8'h09, 8'h62, 4'd6, 64'h0, 0, TRIES - 1, "R6");
    run_txn(0, 8'h0A, 8'h63, 4'd6, 64'h0, 0, TRIES, "R7");
    run_txn(0, 8'h0B, 8'h64, 4'd3, 64'h0, 0, 0, "R11");
    run_txn(1, 8'h0C, 8'h65, 4'd0, 64'h1, 0, 0, "R11");
    run_txn(0, 8'h0D, 8'h66, 4'd9, 64'h0, 0, 0, "R11");

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      bit w;
      int ln;
      w  = 1'($urandom);
      ln = lens[$urandom % 5];
      run_txn(w, 8'($urandom), 8'($urandom), 4'(ln), {$urandom, $urandom},
              int'($urandom % 4), int'($urandom % 4), w ? "R5" : "R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule